// File: doc/BRIEF.md
# Half-Bridge Gate-Drive Sequencer

This block turns one PWM command into the high-side and low-side gate enables of a single half-bridge. It does not use a fixed dead-time count. Before it enables the incoming gate, it waits until the comparator of the outgoing gate reports that gate as discharged. It then waits a further programmable digital guard time, and only after that does it turn the incoming gate on.

Each switching event also opens a timed window of cfg_tdrive cycles. During the window a strong pulldown holds the gate that must stay off. When the window closes, both gate comparators are checked. If the incoming gate has not charged, or the outgoing gate has not discharged, the block latches a gate fault. The fault forces both gates off until software pulses a clear. A fresh PWM command ends a running window at once, so the window never stretches PWM timing.

The PWM input and both comparator inputs pass through two-flop synchronizers. The two timing values are sampled from configuration inputs when they are needed. The block is placed between a PWM generator and the analog gate drivers of one phase.

Top module: `hb_gate_seq`

## Requirements
- R1: A change on pwm_in is acted on at the third rising clock edge after the change. At that edge the enable of the outgoing gate drops. Two synchronizer flops come first, then the sequencer register.
- R2: The incoming gate enable stays low for as long as the outgoing gate's comparator input reads 1 (1 = gate voltage above threshold). There is no time limit on this wait.
- R3: When the outgoing comparator input falls after a command, the incoming enable rises at the (cfg_tdead+4)-th rising edge after the fall. cfg_tdead is sampled when the handshake completes.
- R4: The strong pulldown of the gate opposite the commanded side is asserted starting at the R1 edge, for cfg_tdrive+1 cycles. A command of 1 (high side on) asserts ls_pd. A command of 0 asserts hs_pd. The two pulldowns are never asserted together.
- R5: At the edge that closes an uninterrupted window, gate_flt is set in two cases: the incoming gate's comparator reads 0, or the outgoing gate's comparator reads 1.
- R6: A new command that takes effect while a window is open ends that window. The ended window is not evaluated for a fault, and a new window starts for the new command.
- R7: While gate_flt is 1, hs_en, ls_en, hs_pd and ls_pd are all 0, and gate_flt stays 1. A one-cycle pulse on flt_clr clears gate_flt at the next edge. The block then re-sequences toward the present PWM command.
- R8: hs_en and ls_en are never 1 in the same cycle. During reset all five outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| pwm_in | input | 1 | PWM command: 1 = high side on, 0 = low side on (asynchronous) |
| vgs_hi_on | input | 1 | High-side gate comparator, 1 = above threshold (asynchronous) |
| vgs_lo_on | input | 1 | Low-side gate comparator, 1 = above threshold (asynchronous) |
| cfg_tdrive | input | CNT_W | Window length in cycles, sampled when a switching event starts |
| cfg_tdead | input | CNT_W | Digital guard time in cycles, sampled at handshake completion |
| flt_clr | input | 1 | Synchronous fault clear pulse |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| hs_pd | output | 1 | High-side strong pulldown enable |
| ls_pd | output | 1 | Low-side strong pulldown enable |
| gate_flt | output | 1 | Latched gate fault |

## Verification
The checker watches four things on every cycle: the two enables are never on together, the two pulldowns are never on together, a fault holds the gates and pulldowns off and persists until cleared, and an enable only rises after the synchronized opposite comparator reads low. Several behaviours need timed scenarios and can only be shown by the bench: the exact synchronizer latency, the cfg_tdead+4 edge distance after the comparator falls, the pulldown window length, fault evaluation at the window's final edge for both failure kinds, the preempted window that must not fault, and re-sequencing after a clear.

// File: rtl/hbgs_pkg.sv
package hbgs_pkg;
  // Sequencer phases: idle-after-reset/clear, waiting for the outgoing gate,
  // guard time, gate conducting, latched fault.
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_HSK  = 3'd1,
    ST_DEAD = 3'd2,
    ST_ON   = 3'd3,
    ST_FLT  = 3'd4
  } seq_st_e;
endpackage

// File: rtl/hbgs_sync.sv
// Multi-bit bank of independent flop chains for asynchronous single-bit inputs.
module hbgs_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2   // must be at least 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbgs_dcnt.sv
// Loadable down counter that stops at zero.
module hbgs_dcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;
  logic         cnt_ce;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_ce = ld || (dec && (cnt != '0));
    cnt_d  = ld ? ld_val : (cnt - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_ce) cnt <= cnt_d;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/hbgs_ctrl.sv
// Switching state machine: handshake, guard time, pulldown window, fault latch.
module hbgs_ctrl
  import hbgs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_s,
  input  logic vh_s,
  input  logic vl_s,
  input  logic flt_clr,
  input  logic win_zero,
  input  logic dead_zero,
  output logic win_ld,
  output logic win_dec,
  output logic dead_ld,
  output logic dead_dec,
  output logic hs_en,
  output logic ls_en,
  output logic hs_pd,
  output logic ls_pd,
  output logic gate_flt
);
  seq_st_e st, st_d;
  logic    tgt, tgt_d;       // commanded side: 1 = high side
  logic    win_act, win_d;
  logic    hs_d, ls_d;
  logic    in_v, out_v;
  logic    start, win_end, flt_hit;

  always_comb begin
    in_v    = tgt ? vh_s : vl_s;
    out_v   = tgt ? vl_s : vh_s;
    start   = (st != ST_FLT) && ((st == ST_OFF) || (pwm_s != tgt));
    win_end = win_act && win_zero && !start;
    flt_hit = (st != ST_FLT) && win_end && (!in_v || out_v);

    st_d  = st;
    tgt_d = tgt;
    win_d = win_act;
    if (st == ST_FLT) begin
      if (flt_clr) st_d = ST_OFF;
    end else if (flt_hit) begin
      st_d  = ST_FLT;
      win_d = 1'b0;
    end else if (start) begin
      st_d  = ST_HSK;
      tgt_d = pwm_s;
      win_d = 1'b1;
    end else begin
      if (win_end) win_d = 1'b0;
      case (st)
        ST_HSK:  if (!out_v) st_d = ST_DEAD;
        ST_DEAD: begin
          if (out_v)          st_d = ST_HSK;
          else if (dead_zero) st_d = ST_ON;
        end
        default: st_d = st;
      endcase
    end

    hs_d     = (st_d == ST_ON) && tgt_d;
    ls_d     = (st_d == ST_ON) && !tgt_d;
    win_ld   = start;
    win_dec  = win_act && !start;
    dead_ld  = (st == ST_HSK) && (st_d == ST_DEAD);
    dead_dec = (st == ST_DEAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_OFF;
      tgt     <= 1'b0;
      win_act <= 1'b0;
      hs_en   <= 1'b0;
      ls_en   <= 1'b0;
    end else begin
      st      <= st_d;
      tgt     <= tgt_d;
      win_act <= win_d;
      hs_en   <= hs_d;
      ls_en   <= ls_d;
    end
  end

  assign hs_pd    = win_act && !tgt;
  assign ls_pd    = win_act && tgt;
  assign gate_flt = (st == ST_FLT);
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             vgs_hi_on,
  input  logic             vgs_lo_on,
  input  logic [CNT_W-1:0] cfg_tdrive,
  input  logic [CNT_W-1:0] cfg_tdead,
  input  logic             flt_clr,
  output logic             hs_en,
  output logic             ls_en,
  output logic             hs_pd,
  output logic             ls_pd,
  output logic             gate_flt
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in, syn_out;
  logic pwm_s, vh_s, vl_s;
  logic win_ld, win_dec, win_zero;
  logic dead_ld, dead_dec, dead_zero;

  assign raw_in = {pwm_in, vgs_hi_on, vgs_lo_on};
  assign {pwm_s, vh_s, vl_s} = syn_out;

  hbgs_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_out)
  );

  hbgs_dcnt #(.W(CNT_W)) u_win_cnt (
    .clk(clk), .rst_n(rst_n), .ld(win_ld), .ld_val(cfg_tdrive),
    .dec(win_dec), .zero(win_zero)
  );

  hbgs_dcnt #(.W(CNT_W)) u_dead_cnt (
    .clk(clk), .rst_n(rst_n), .ld(dead_ld), .ld_val(cfg_tdead),
    .dec(dead_dec), .zero(dead_zero)
  );

  hbgs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwm_s(pwm_s), .vh_s(vh_s), .vl_s(vl_s),
    .flt_clr(flt_clr), .win_zero(win_zero), .dead_zero(dead_zero),
    .win_ld(win_ld), .win_dec(win_dec), .dead_ld(dead_ld), .dead_dec(dead_dec),
    .hs_en(hs_en), .ls_en(ls_en), .hs_pd(hs_pd), .ls_pd(ls_pd),
    .gate_flt(gate_flt)
  );
endmodule

// File: rtl/hbgs_chk.sv
module hbgs_chk (
  input logic clk,
  input logic rst_n,
  input logic hs_en,
  input logic ls_en,
  input logic hs_pd,
  input logic ls_pd,
  input logic gate_flt,
  input logic flt_clr,
  input logic vh_s,
  input logic vl_s
);
  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en)); // R8

  AST_PD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_pd && ls_pd)); // R4

  AST_FLT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    gate_flt |-> (!hs_en && !ls_en && !hs_pd && !ls_pd)); // R7

  AST_FLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_flt && !flt_clr) |=> gate_flt); // R7

  AST_HS_AFTER_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> !$past(vl_s)); // R2

  AST_LS_AFTER_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> !$past(vh_s)); // R2
endmodule

bind hb_gate_seq hbgs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .ls_en(ls_en), .hs_pd(hs_pd),
  .ls_pd(ls_pd), .gate_flt(gate_flt), .flt_clr(flt_clr), .vh_s(vh_s), .vl_s(vl_s)
);

// File: tb/sim_hb_gate_seq.sv
`timescale 1ns/1ps
module sim_hb_gate_seq;
  localparam int TD = 20;  // window length
  localparam int TE = 3;   // guard time

  // output vector bit order: {gate_flt, hs_pd, ls_pd, hs_en, ls_en}
  localparam logic [4:0] M_LS  = 5'b00001;
  localparam logic [4:0] M_HS  = 5'b00010;
  localparam logic [4:0] M_LPD = 5'b00100;
  localparam logic [4:0] M_HPD = 5'b01000;
  localparam logic [4:0] M_FLT = 5'b10000;
  localparam logic [4:0] M_ALL = 5'b11111;

  typedef struct {
    int         at;
    logic [4:0] mask;
    logic [4:0] val;
    string      tag;
  } exp_t;

  logic clk, rst_n, pwm_in, vgs_hi_on, vgs_lo_on, flt_clr;
  logic [7:0] cfg_tdrive, cfg_tdead;
  logic hs_en, ls_en, hs_pd, ls_pd, gate_flt;
  logic [4:0] obs;
  int cyc, n_cmp, n_bad;
  bit done;
  exp_t sb[$];
  exp_t it;

  hb_gate_seq u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .vgs_hi_on(vgs_hi_on),
    .vgs_lo_on(vgs_lo_on), .cfg_tdrive(cfg_tdrive), .cfg_tdead(cfg_tdead),
    .flt_clr(flt_clr), .hs_en(hs_en), .ls_en(ls_en), .hs_pd(hs_pd),
    .ls_pd(ls_pd), .gate_flt(gate_flt)
  );

  assign obs = {gate_flt, hs_pd, ls_pd, hs_en, ls_en};

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic want(input int at, input logic [4:0] m, input logic [4:0] v,
                      input string t);
    sb.push_back(exp_t'{at, m, v, t});
  endtask

  task automatic go(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: pops expectations whose cycle has come and compares
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      it = sb.pop_front();
      n_cmp++;
      if (it.at != cyc || ((obs ^ it.val) & it.mask) != 5'b0) begin
        n_bad++;
        $display("FAIL %s cyc=%0d actual=%b expected=%b mask=%b",
                 it.tag, cyc, obs, it.val, it.mask);
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1 cyc=%0d actual=running expected=finished", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int p;
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; pwm_in = 1'b0; vgs_hi_on = 1'b0; vgs_lo_on = 1'b0;
    flt_clr = 1'b0; cfg_tdrive = 8'(TD); cfg_tdead = 8'(TE);
    repeat (2) @(negedge clk);
    want(cyc + 1, M_ALL, 5'b00000, "R8 reset outputs");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    p = cyc;
    go(p + 8); vgs_lo_on = 1'b1;             // low gate charges after startup
    want(p + 40, M_ALL, 5'b00001, "R3 low side settled after reset");
    go(p + 40);

    // A: rise, normal handshake
    go(p + 45); p = cyc;
    pwm_in = 1'b1;
    want(p + 2,  M_LS | M_LPD, 5'b00001, "R1 no action before third edge");
    want(p + 3,  M_ALL, 5'b00100, "R1 outgoing off, R4 ls_pd on");
    want(p + 12, M_HS, 5'b00000, "R2 high waits for low off");
    want(p + TE + 9, M_HS, 5'b00000, "R3 one edge early");
    want(p + TE + 10, M_HS | M_LS, 5'b00010, "R3 high enabled after guard");
    want(p + 23, M_LPD, 5'b00100, "R4 pulldown last cycle");
    want(p + 24, M_ALL, 5'b00010, "R4 pulldown ends, R5 no fault");
    go(p + 6);  vgs_lo_on = 1'b0;
    go(p + 15); vgs_hi_on = 1'b1;
    go(p + 30);

    // B: fall, normal handshake
    p = cyc;
    pwm_in = 1'b0;
    want(p + 3,  M_ALL, 5'b01000, "R4 hs_pd on for low command");
    want(p + 11, M_LS, 5'b00000, "R3 one edge early");
    want(p + 12, M_LS | M_HS, 5'b00001, "R3 low enabled after guard");
    want(p + 23, M_HPD, 5'b01000, "R4 hs_pd last cycle");
    want(p + 24, M_ALL, 5'b00001, "R5 no fault after good switch");
    go(p + 5);  vgs_hi_on = 1'b0;
    go(p + 14); vgs_lo_on = 1'b1;
    go(p + 30);

    // C: command withdrawn inside the window
    p = cyc;
    pwm_in = 1'b1;
    want(p + 10, M_LPD | M_HPD, 5'b00100, "R6 first window still open");
    want(p + 11, M_ALL, 5'b01000, "R6 new window on other side");
    want(p + 14, M_HS, 5'b00000, "R6 high never enabled");
    want(p + 15, M_LS, 5'b00000, "R3 low re-enable one edge early");
    want(p + 16, M_LS | M_HS, 5'b00001, "R3 low re-enabled");
    want(p + 24, M_FLT, 5'b00000, "R6 ended window not evaluated");
    want(p + 32, M_ALL, 5'b00001, "R6 new window closes without fault");
    go(p + 8); pwm_in = 1'b0;
    go(p + 40);

    // D: incoming gate never charges
    p = cyc;
    pwm_in = 1'b1;
    want(p + 13, M_HS, 5'b00010, "R3 high enabled");
    want(p + 23, M_FLT | M_HS, 5'b00010, "R5 no fault before window end");
    want(p + 24, M_ALL, 5'b10000, "R5 fault, R7 all off");
    want(p + 40, M_ALL, 5'b10000, "R7 fault latched");
    want(p + 45, M_FLT, 5'b10000, "R7 fault held until clear edge");
    want(p + 46, M_ALL, 5'b00000, "R7 fault cleared");
    want(p + 47, M_ALL, 5'b00100, "R7 re-sequence starts");
    want(p + 52, M_HS | M_LS, 5'b00010, "R7 high enabled after clear");
    want(p + 68, M_FLT | M_HS, 5'b00010, "R5 no fault after recovery");
    go(p + 6);  vgs_lo_on = 1'b0;
    go(p + 45); flt_clr = 1'b1;
    go(p + 46); flt_clr = 1'b0;
    go(p + 53); vgs_hi_on = 1'b1;
    go(p + 75);

    // E: outgoing gate stays charged
    p = cyc;
    pwm_in = 1'b0;
    want(p + 3,  M_HS | M_HPD, 5'b01000, "R1 high drops, R4 hs_pd");
    want(p + 20, M_LS, 5'b00000, "R2 low held off while high reads on");
    want(p + 24, M_ALL, 5'b10000, "R5 fault on stuck outgoing gate");
    want(p + 36, M_FLT, 5'b00000, "R7 fault cleared");
    want(p + 42, M_LS | M_HS, 5'b00001, "R7 low enabled after clear");
    want(p + 58, M_FLT, 5'b00000, "R5 no fault after recovery");
    go(p + 30); vgs_hi_on = 1'b0;
    go(p + 35); flt_clr = 1'b1;
    go(p + 36); flt_clr = 1'b0;
    go(p + 43); vgs_lo_on = 1'b1;
    go(p + 65);

    done = 1'b1;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R1 pending=%0d expected=0", sb.size());
    end
    summary();
    $finish;
  end
endmodule